// File: doc/BRIEF.md
# Pair-and-Swap Redundancy Manager

This controller supervises an array of 2·NPAIR processor cores that run in lockstep pairs. It holds a pairing map that puts every core into one of NPAIR pair slots. For each active slot it compares the result words that the two partners report. A comparison takes place at every point where both partners strobe a result, and not only when a task completes. When a pair disagrees, the controller does not vote. It moves one partner into a second healthy pair and asks both slots to roll back to their latest checkpoint. The outcome of the re-run then tells it whether the fault was transient or whether one particular core is permanently broken.

A broken core is masked off for good. Its healthy former partner is set aside as a spare, and the next core that becomes spare joins it to form a new pair. The array therefore keeps running with fewer pairs instead of stopping. The cores, the checkpoint storage and the reliability model are outside this block. The controller only issues rollback requests and publishes the map, the slot-active flags, the disable mask and the fault events.

Top module: `pns_mgr`

## Requirements
- R1: After reset, slot p holds cores (2p, 2p+1) as members 0 and 1. All slots are active, the disable mask is zero, no fault flag is set and the controller is not busy.
- R2: A slot is compared only in a cycle in which both of its members strobe valid. If the two words are equal, the map, the rollback outputs and the flags stay unchanged.
- R3: When an active slot f with members (A,B) disagrees while no diagnosis runs, it is paired with the lowest-numbered other active slot g with members (C,D). One clock later f holds (A,C) and g holds (B,D). The rollback bits of f and g pulse high for one cycle and busy rises.
- R4: A lone valid strobe from one member of a slot starts a wait. If no cycle with both members valid follows within tmo_lim cycles, a mismatch is raised in the cycle when the wait has lasted tmo_lim cycles. The rollback appears on the next clock.
- R5: If both re-run slots then agree, the transient flag pulses for one cycle, busy falls and the swapped map is kept.
- R6: If exactly one re-run slot disagrees, the core in it that came from the original failing pair is declared faulty. That core is A for slot f and B for slot g. Its disable-mask bit is set and never clears, the permanent flag pulses for one cycle, and the fault-core output carries its number.
- R7: The other member of the faulty core's slot becomes a spare and the slot goes inactive. If a spare is already held, the slot instead becomes (survivor, held spare) and stays active.
- R8: Inactive slots are never compared and never raise a mismatch.
- R9: A mismatch on a slot outside the running diagnosis is held in a single pending entry. It starts its own diagnosis on the cycle after the running one ends.
- R10: If both re-run slots disagree, or if no partner slot exists, the fatal flag rises and stays set. From then on the controller ignores all mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_lim | input | TW | Number of cycles a lone strobe may wait for its partner |
| res_valid | input | 2·NPAIR | Per-core result strobe |
| res_data | input | 2·NPAIR·W | Per-core result word; core c uses bits [c·W +: W] |
| pair_map | output | NPAIR·2·IDW | Member m of slot p at bits [(2p+m)·IDW +: IDW] |
| pair_act | output | NPAIR | Slot-active flags |
| rollback | output | NPAIR | One-cycle rollback request per slot |
| diag_busy | output | 1 | A swap and re-run is in progress |
| flt_transient | output | 1 | One-cycle pulse: fault classed transient |
| flt_perm | output | 1 | One-cycle pulse: permanent fault isolated |
| flt_core | output | IDW | Number of the last isolated core |
| flt_fatal | output | 1 | Sticky unrecoverable-fault flag |
| core_off | output | 2·NPAIR | Disable mask, one bit per core |

## Verification
The bench drives the swap twice through the same core. It checks that the second swap builds its pairs from the already-rotated map, so a design that recomputed pairs from the reset layout would publish the wrong cores. The re-run cycle in which the fault is resolved also carries a mismatch on an unrelated slot. A design that dropped it, or that started it before the first diagnosis closed, would show the wrong rollback bits one cycle later. Further checks cover a second isolation that must consume the held spare instead of deactivating a slot, the exact cycle at which a lone-strobe timeout fires, the silence of a deactivated slot, and the double disagreement that must latch the fatal flag.

// File: rtl/pns_pkg.sv
package pns_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RERUN = 2'd1,
        ST_DEAD  = 2'd2
    } pns_state_e;
endpackage

// File: rtl/pns_pair_cmp.sv
module pns_pair_cmp #(
    parameter int NCORE = 8,
    parameter int W     = 16,
    parameter int TW    = 8,
    localparam int IDW  = $clog2(NCORE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_i,
    input  logic               clr_i,
    input  logic [IDW-1:0]     id_a_i,
    input  logic [IDW-1:0]     id_b_i,
    input  logic [NCORE-1:0]   res_valid_i,
    input  logic [NCORE*W-1:0] res_data_i,
    input  logic [TW-1:0]      tmo_lim_i,
    output logic               ev_o,
    output logic               bad_o
);
    typedef struct packed {
        logic          wait_on;
        logic [TW-1:0] cnt;
    } cmp_st_t;

    cmp_st_t q, d;
    logic va, vb, both, lone, tmo;
    logic [W-1:0] da, db;

    always_comb begin
        va   = res_valid_i[id_a_i];
        vb   = res_valid_i[id_b_i];
        da   = res_data_i[id_a_i*W +: W];
        db   = res_data_i[id_b_i*W +: W];
        both = act_i && va && vb;
        lone = act_i && (va ^ vb);
        tmo  = act_i && q.wait_on && (q.cnt >= tmo_lim_i);
        ev_o = both || tmo;
        bad_o = both ? (da != db) : tmo;
    end

    always_comb begin
        d = q;
        if (clr_i || !act_i || ev_o) begin
            d.wait_on = 1'b0;
            d.cnt     = '0;
        end else if (q.wait_on) begin
            d.cnt = q.cnt + TW'(1);
        end else if (lone) begin
            d.wait_on = 1'b1;
            d.cnt     = TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: an outcome without both strobes can only come out of a wait
    a_r4_tmo_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o && !(va && vb)) |-> q.wait_on);
    // R8: an inactive slot keeps no wait state
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> !q.wait_on);
endmodule

// File: rtl/pns_ctl.sv
module pns_ctl
    import pns_pkg::*;
#(
    parameter int NPAIR = 4,
    localparam int NCORE = 2 * NPAIR,
    localparam int IDW   = $clog2(NCORE),
    localparam int PW    = $clog2(NPAIR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPAIR-1:0]       ev_i,
    input  logic [NPAIR-1:0]       bad_i,
    output logic [NPAIR*2*IDW-1:0] map_o,
    output logic [NPAIR-1:0]       act_o,
    output logic [NPAIR-1:0]       rb_o,
    output logic [NPAIR-1:0]       clr_o,
    output logic                   busy_o,
    output logic                   trans_o,
    output logic                   perm_o,
    output logic [IDW-1:0]         fcore_o,
    output logic                   fatal_o,
    output logic [NCORE-1:0]       off_o
);
    typedef struct packed {
        pns_state_e                      st;
        logic [NPAIR-1:0][1:0][IDW-1:0]  map;
        logic [NPAIR-1:0]                act;
        logic [NCORE-1:0]                off;
        logic                            spare_v;
        logic [IDW-1:0]                  spare_id;
        logic                            pend_v;
        logic [PW-1:0]                   pend_id;
        logic [PW-1:0]                   fp;
        logic [PW-1:0]                   gp;
        logic                            df, bf, dg, bg;
        logic [NPAIR-1:0]                rb;
        logic                            trans;
        logic                            perm;
        logic [IDW-1:0]                  fcore;
        logic                            fatal;
    } ctl_st_t;

    ctl_st_t q, d;
    logic hit, ohit, start, gfound, df, bf, dg, bg;
    logic [PW-1:0] hp, op, sp, gsel, slot;
    logic [IDW-1:0] faulty, surv;

    always_comb begin
        d = q;
        d.rb = '0;
        d.trans = 1'b0;
        d.perm = 1'b0;
        hit = 1'b0; hp = '0; ohit = 1'b0; op = '0;
        start = 1'b0; sp = '0; gfound = 1'b0; gsel = '0;
        df = 1'b0; bf = 1'b0; dg = 1'b0; bg = 1'b0;
        slot = '0; faulty = '0; surv = '0;
        for (int p = NPAIR - 1; p >= 0; p--) begin
            if (q.act[p] && ev_i[p] && bad_i[p]) begin
                hit = 1'b1;
                hp  = PW'(p);
                if (PW'(p) != q.fp && PW'(p) != q.gp) begin
                    ohit = 1'b1;
                    op   = PW'(p);
                end
            end
        end
        case (q.st)
            ST_IDLE: begin
                if (q.pend_v) begin
                    sp = q.pend_id;
                    start = q.act[q.pend_id];
                    d.pend_v = 1'b0;
                    if (hit && hp != q.pend_id) begin
                        d.pend_v  = 1'b1;
                        d.pend_id = hp;
                    end
                end else if (hit) begin
                    sp = hp;
                    start = 1'b1;
                end
                if (start) begin
                    for (int p = NPAIR - 1; p >= 0; p--) begin
                        if (q.act[p] && PW'(p) != sp) begin
                            gfound = 1'b1;
                            gsel   = PW'(p);
                        end
                    end
                    if (!gfound) begin
                        d.fatal = 1'b1;
                        d.st    = ST_DEAD;
                    end else begin
                        d.map[sp][1]   = q.map[gsel][0];
                        d.map[gsel][0] = q.map[sp][1];
                        d.rb[sp]   = 1'b1;
                        d.rb[gsel] = 1'b1;
                        d.fp = sp;
                        d.gp = gsel;
                        d.df = 1'b0; d.bf = 1'b0; d.dg = 1'b0; d.bg = 1'b0;
                        d.st = ST_RERUN;
                    end
                end
            end
            ST_RERUN: begin
                df = q.df || ev_i[q.fp];
                bf = q.df ? q.bf : bad_i[q.fp];
                dg = q.dg || ev_i[q.gp];
                bg = q.dg ? q.bg : bad_i[q.gp];
                if (ohit && !q.pend_v) begin
                    d.pend_v  = 1'b1;
                    d.pend_id = op;
                end
                if (df && dg) begin
                    d.st = ST_IDLE;
                    if (!bf && !bg) begin
                        d.trans = 1'b1;
                    end else if (bf && bg) begin
                        d.fatal = 1'b1;
                        d.st    = ST_DEAD;
                    end else begin
                        slot   = bf ? q.fp : q.gp;
                        faulty = q.map[slot][0];
                        surv   = q.map[slot][1];
                        d.off[faulty] = 1'b1;
                        d.perm  = 1'b1;
                        d.fcore = faulty;
                        if (q.spare_v) begin
                            d.map[slot][0] = surv;
                            d.map[slot][1] = q.spare_id;
                            d.spare_v = 1'b0;
                        end else begin
                            d.spare_v  = 1'b1;
                            d.spare_id = surv;
                            d.act[slot] = 1'b0;
                        end
                    end
                end else begin
                    d.df = df; d.bf = bf; d.dg = dg; d.bg = bg;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= ST_IDLE;
            q.act <= '1;
            for (int p = 0; p < NPAIR; p++) begin
                q.map[p][0] <= IDW'(2 * p);
                q.map[p][1] <= IDW'(2 * p + 1);
            end
        end else begin
            q <= d;
        end
    end

    assign map_o   = q.map;
    assign act_o   = q.act;
    assign rb_o    = q.rb;
    assign clr_o   = d.rb;
    assign busy_o  = (q.st == ST_RERUN);
    assign trans_o = q.trans;
    assign perm_o  = q.perm;
    assign fcore_o = q.fcore;
    assign fatal_o = q.fatal;
    assign off_o   = q.off;

    // R3: a rollback always names exactly two slots
    a_r3_rb_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rb == '0) || ($countones(q.rb) == 2));
    // R3: rollback only while the re-run is pending
    a_r3_rb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.rb) |-> (q.st == ST_RERUN));
    // R10: fatal is sticky
    a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.fatal |=> q.fatal);
    // R6: disable bits never clear
    a_r6_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(q.off) & ~q.off) == '0));
    // R5: a diagnosis has one classification
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.trans && q.perm));
endmodule

// File: rtl/pns_mgr.sv
module pns_mgr #(
    parameter int NPAIR = 4,
    parameter int W     = 16,
    parameter int TW    = 8,
    localparam int NCORE = 2 * NPAIR,
    localparam int IDW   = $clog2(NCORE)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TW-1:0]          tmo_lim,
    input  logic [NCORE-1:0]       res_valid,
    input  logic [NCORE*W-1:0]     res_data,
    output logic [NPAIR*2*IDW-1:0] pair_map,
    output logic [NPAIR-1:0]       pair_act,
    output logic [NPAIR-1:0]       rollback,
    output logic                   diag_busy,
    output logic                   flt_transient,
    output logic                   flt_perm,
    output logic [IDW-1:0]         flt_core,
    output logic                   flt_fatal,
    output logic [NCORE-1:0]       core_off
);
    logic [NPAIR-1:0] ev, bad, clr;

    for (genvar p = 0; p < NPAIR; p++) begin : g_cmp
        pns_pair_cmp #(.NCORE(NCORE), .W(W), .TW(TW)) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (pair_act[p]),
            .clr_i      (clr[p]),
            .id_a_i     (pair_map[(2*p)*IDW +: IDW]),
            .id_b_i     (pair_map[(2*p+1)*IDW +: IDW]),
            .res_valid_i(res_valid),
            .res_data_i (res_data),
            .tmo_lim_i  (tmo_lim),
            .ev_o       (ev[p]),
            .bad_o      (bad[p])
        );
    end

    pns_ctl #(.NPAIR(NPAIR)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .bad_i  (bad),
        .map_o  (pair_map),
        .act_o  (pair_act),
        .rb_o   (rollback),
        .clr_o  (clr),
        .busy_o (diag_busy),
        .trans_o(flt_transient),
        .perm_o (flt_perm),
        .fcore_o(flt_core),
        .fatal_o(flt_fatal),
        .off_o  (core_off)
    );
endmodule

// File: tb/pns_mgr_bench.sv
module pns_mgr_bench;
    localparam int NPAIR = 4;
    localparam int W     = 16;
    localparam int TW    = 8;
    localparam int NCORE = 2 * NPAIR;
    localparam int IDW   = $clog2(NCORE);
    localparam int NV    = 7;

    localparam logic [NCORE-1:0] TV_V  [NV] = '{8'hFF, 8'h0F, 8'hF0, 8'h33, 8'h01, 8'hFF, 8'hCC};
    localparam logic [W-1:0]     TV_D  [NV] = '{16'h1234, 16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'h8001};
    localparam logic [NPAIR-1:0] TV_RB [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] tmo_lim = 8'd100;
    logic [NCORE-1:0] res_valid = '0;
    logic [NCORE*W-1:0] res_data = '0;
    logic [NPAIR*2*IDW-1:0] pair_map;
    logic [NPAIR-1:0] pair_act, rollback;
    logic diag_busy, flt_transient, flt_perm, flt_fatal;
    logic [IDW-1:0] flt_core;
    logic [NCORE-1:0] core_off;
    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    pns_mgr #(.NPAIR(NPAIR), .W(W), .TW(TW)) u_pns_mgr (
        .clk(clk), .rst_n(rst_n), .tmo_lim(tmo_lim), .res_valid(res_valid),
        .res_data(res_data), .pair_map(pair_map), .pair_act(pair_act),
        .rollback(rollback), .diag_busy(diag_busy), .flt_transient(flt_transient),
        .flt_perm(flt_perm), .flt_core(flt_core), .flt_fatal(flt_fatal),
        .core_off(core_off)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chkpair(input string tag, input int p, input int a, input int b);
        chk(tag, 32'(pair_map[(2*p)*IDW +: IDW]) * 16 + 32'(pair_map[(2*p+1)*IDW +: IDW]),
            32'(a * 16 + b));
    endtask

    task automatic step(input logic [NCORE-1:0] v, input logic [NCORE-1:0] bm, input logic [W-1:0] base);
        for (int c = 0; c < NCORE; c++)
            res_data[c*W +: W] = bm[c] ? (base ^ 16'h00FF) : base;
        res_valid = v;
        @(posedge clk);
        #2;
        res_valid = '0;
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1 reset state
        for (int p = 0; p < NPAIR; p++) chkpair("R1 reset map", p, 2*p, 2*p+1);
        chk("R1 act", 32'(pair_act), 32'hF);
        chk("R1 mask", 32'(core_off), 0);
        chk("R1 flags", {29'd0, diag_busy, flt_fatal, flt_perm}, 0);

        // R2 agreeing vectors, several valid patterns (entry 4 is a lone strobe, then cleared)
        for (int i = 0; i < NV; i++) begin
            step(TV_V[i], '0, TV_D[i]);
            chk("R2 table rollback", 32'(rollback), 32'(TV_RB[i]));
            chk("R2 table busy", 32'(diag_busy), 0);
        end
        chkpair("R2 map kept", 0, 0, 1);

        // R3 swap on slot 0 mismatch
        step(8'hFF, 8'h02, 16'h1111);
        chk("R3 rollback", 32'(rollback), 32'h3);
        chk("R3 busy", 32'(diag_busy), 1);
        chkpair("R3 slot0", 0, 0, 2);
        chkpair("R3 slot1", 1, 1, 3);
        // R5 transient
        step(8'hFF, 8'h00, 16'h2222);
        chk("R5 transient", 32'(flt_transient), 1);
        chk("R5 busy low", 32'(diag_busy), 0);
        chkpair("R5 map kept", 0, 0, 2);
        step(8'h00, 8'h00, 16'h0);
        chk("R5 pulse one cycle", 32'(flt_transient), 0);

        // R6 permanent on core 1: slot1 (1,3) with slot0 (0,2)
        step(8'hFF, 8'h02, 16'h3333);
        chk("R3 second rollback", 32'(rollback), 32'h3);
        chkpair("R3 slot1 rotated", 1, 1, 0);
        chkpair("R3 slot0 rotated", 0, 3, 2);
        step(8'hFF, 8'h02, 16'h4444);
        chk("R6 perm", 32'(flt_perm), 1);
        chk("R6 core", 32'(flt_core), 1);
        chk("R6 mask", 32'(core_off), 32'h02);
        chk("R7 slot1 inactive", 32'(pair_act), 32'hD);

        // R8 inactive slot ignored
        step(8'hFF, 8'h02, 16'h5555);
        chk("R8 no rollback", 32'(rollback), 0);
        chk("R8 not busy", 32'(diag_busy), 0);

        // R4 timeout on slot3 (6,7)
        tmo_lim = 8'd4;
        step(8'h40, 8'h00, 16'h6666);
        for (int k = 0; k < 3; k++) step(8'h00, 8'h00, 16'h0);
        chk("R4 not yet", 32'(diag_busy), 0);
        step(8'h00, 8'h00, 16'h0);
        chk("R4 timeout rollback", 32'(rollback), 32'h9);
        chkpair("R4 slot3", 3, 6, 3);
        chkpair("R4 slot0", 0, 7, 2);
        step(8'hFF, 8'h00, 16'h7777);
        chk("R5 transient after timeout", 32'(flt_transient), 1);

        // R9 and R7: core 4 faulty, slot3 mismatches during resolution
        step(8'hFF, 8'h10, 16'h8888);
        chk("R3 slot2 rollback", 32'(rollback), 32'h5);
        chkpair("R3 slot2", 2, 4, 7);
        step(8'hFF, 8'h50, 16'h9999);
        chk("R6 core4", 32'(flt_core), 4);
        chk("R6 mask2", 32'(core_off), 32'h12);
        chkpair("R7 spare used", 2, 7, 0);
        chk("R7 slot2 active", 32'(pair_act), 32'hD);
        chk("R9 not yet", 32'(rollback), 0);
        step(8'h00, 8'h00, 16'h0);
        chk("R9 pending launched", 32'(rollback), 32'h9);
        chkpair("R9 slot3", 3, 6, 5);
        chkpair("R9 slot0", 0, 3, 2);

        // R10 double disagreement
        step(8'hFF, 8'h44, 16'hAAAA);
        chk("R10 fatal", 32'(flt_fatal), 1);
        chk("R10 busy", 32'(diag_busy), 0);
        step(8'hFF, 8'h80, 16'hBBBB);
        chk("R10 ignored", 32'(rollback), 0);
        chk("R10 sticky", 32'(flt_fatal), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule